// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block runs one vectorised two-source operation element by element. When `start` arrives it takes a snapshot of the vector length, the predicate selection, the mode bits and the mask sources. It then steps an element index from 0 up to VL-1, one element per cycle. For each element it forms a predicate from one of two sources: an integer mask register (three candidate registers) or a bank of 4-bit condition fields. An element that is enabled is issued to an external combinational ALU port. The ALU's result and condition nibble then go to two register-file write ports.

Three modes shape the writes. Plain vectorisation writes every enabled element. Data-dependent fail-on-first tests one bit of each new condition nibble. The first failure discards that element and all later ones, and the reported VL is cut to the index of the failing element, which can be zero. Predicate-result mode always stores the condition nibble, but cancels the result store when the test fails. Zeroing turns a skipped result into a write of zero. When a run ends, `done` pulses for one cycle and `vlOut` holds the final length.

Top module: `vec_elem_seq`

## Requirements
- R1: After `start` is accepted with VL>0, element i is presented in the i-th cycle that follows the accepting edge. `done` is high for exactly one cycle, the cycle after the last element. `vlOut` then equals VL, unless a fail-on-first cut applies.
- R2: Integer predication (`maskKind`=0) uses the 3-bit `maskCode` as follows. 000 enables every element. 001 enables only the element whose index equals `r3Val`. 010 and 011 enable element i when bit i of `r3Val` is set and clear respectively. 100 and 101 apply the same test to `r10Val`, and 110 and 111 apply it to `r30Val`.
- R3: Condition-field predication (`maskKind`=1) reads nibble i of `condBank`, bits [4i+3:4i], as the field at offset 32+i. `maskCode[2:1]` picks a bit of that nibble: 0 is bit 3 (LT), 1 is bit 2 (GT), 2 is bit 1 (EQ) and 3 is bit 0 (SO). `maskCode[0]`=1 inverts the test.
- R4: With VL=0, no element is issued and nothing is written. `done` pulses on the cycle after the accepting edge and `vlOut` reads 0.
- R5: With `zeroEn`=0, a masked-out element raises no ALU request and no write strobe.
- R6: With `zeroEn`=1, a masked-out element raises `resWe` together with `resZero`, with `resData`=0, and it writes no condition field.
- R7: With `rcEn`=1, an issued element that is not discarded writes `aluCond` at condition address 8+i, in the same cycle as its result.
- R8: The element test passes when bit (3-`testSel`) of `aluCond`, XOR `testInv`, equals 1. In fail-on-first mode (`modeSel`=01), the first issued element that fails writes nothing. No later element is issued, `done` follows on the next cycle, and `vlOut` becomes that element's index.
- R9: In fail-on-first mode, a failure at element 0 sets `vlOut` to 0.
- R10: In predicate-result mode (`modeSel`=11), an issued element writes its condition field whenever `rcEn`=1. It writes its result only if the test passes. On a failed test with `zeroEn`=1, it writes a zero result instead. A `modeSel` of 00 or 10 behaves as plain vectorisation.
- R11: Configuration, mask registers and `condBank` are sampled only at the accepting edge. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| vlIn | input | VL_W | Requested vector length |
| maskKind | input | 1 | 0 integer mask, 1 condition-field mask |
| maskCode | input | 3 | Predicate selection code |
| modeSel | input | 2 | 00/10 normal, 01 fail-on-first, 11 predicate-result |
| testInv | input | 1 | Invert the element test |
| testSel | input | 2 | Condition bit tested per element |
| zeroEn | input | 1 | Write zeros for skipped results |
| rcEn | input | 1 | Store per-element condition fields |
| r3Val | input | XLEN | First integer mask source |
| r10Val | input | XLEN | Second integer mask source |
| r30Val | input | XLEN | Third integer mask source |
| condBank | input | 4*MAX_VL | Condition fields 32 onward, nibble i = field 32+i |
| aluResult | input | XLEN | ALU result for `aluIdx` |
| aluCond | input | 4 | ALU condition nibble for `aluIdx` |
| aluReq | output | 1 | Element issued to the ALU this cycle |
| aluIdx | output | IDX_W | Current element index |
| resWe | output | 1 | Result write strobe |
| resZero | output | 1 | Result write is a zeroing write |
| resIdx | output | IDX_W | Result element index |
| resData | output | XLEN | Result write data |
| condWe | output | 1 | Condition field write strobe |
| condAddr | output | CA_W | Condition field address (8+i) |
| condData | output | 4 | Condition field data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| vlOut | output | VL_W | Final vector length, registered |

## Verification
The bench targets the places where the length gets cut. A failure at element 0 must leave `vlOut` at zero; a design that only saves the index of the last good element would report 1 or the full VL. A failure in the middle must stop the write strobes right there, while a design off by one would let the failing element's result through. Predicate-result runs check that the condition nibble is still stored when the result store is cancelled. A design that gates both stores together would drop that condition write. VL=0, the equality code against `r3Val`, every condition-bit selector under inversion, and a `start` raised in the middle of a run catch a sequencer that issues a phantom element, reads the wrong nibble, or takes a new snapshot while busy.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  localparam logic [1:0] MODE_NORMAL = 2'b00;
  localparam logic [1:0] MODE_FFIRST = 2'b01;
  localparam logic [1:0] MODE_PRED   = 2'b11;

  typedef struct packed {
    logic       maskKind;
    logic [2:0] maskCode;
    logic [1:0] modeSel;
    logic       testInv;
    logic [1:0] testSel;
    logic       zeroEn;
    logic       rcEn;
  } seqCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // snapshot configuration this edge
    logic active;  // an element is presented this cycle
  } ctrlStrb_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seqState_t;

  // nibble layout: bit3 LT, bit2 GT, bit1 EQ, bit0 SO
  function automatic logic condBitTest(logic [3:0] fld, logic [1:0] sel, logic inv);
    return fld[2'd3 - sel] ^ inv;
  endfunction

  function automatic logic predOf(logic kind, logic [2:0] code, logic b3,
                                  logic b10, logic b30, logic eq3, logic [3:0] fld);
    logic p;
    if (kind) begin
      p = condBitTest(fld, code[2:1], code[0]);
    end else begin
      case (code)
        3'b000:  p = 1'b1;
        3'b001:  p = eq3;
        3'b010:  p = b3;
        3'b011:  p = ~b3;
        3'b100:  p = b10;
        3'b101:  p = ~b10;
        3'b110:  p = b30;
        default: p = ~b30;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1),
  parameter int IDX_W  = $clog2(MAX_VL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VL_W-1:0]  vlIn,
  input  logic             elemFail,
  output ctrlStrb_t        strb,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done,
  output logic [VL_W-1:0]  vlOut
);

  localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

  seqState_t        stateQ;
  logic [IDX_W-1:0] idxQ;
  logic [VL_W-1:0]  vlQ;
  logic [VL_W-1:0]  vlOutQ;
  logic             doneQ;
  logic [VL_W-1:0]  vlClamped;
  logic             lastElem;

  assign vlClamped = (vlIn > VL_CAP) ? VL_CAP : vlIn;
  assign lastElem  = (idxQ == IDX_W'(vlQ - VL_W'(1)));

  assign strb.load   = start && (stateQ == ST_IDLE);
  assign strb.active = (stateQ == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
      vlQ    <= '0;
      vlOutQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            vlQ  <= vlClamped;
            idxQ <= '0;
            if (vlClamped == '0) begin
              vlOutQ <= '0;
              doneQ  <= 1'b1;
            end else begin
              stateQ <= ST_RUN;
            end
          end
        end
        default: begin
          if (elemFail) begin
            vlOutQ <= VL_W'(idxQ);
            doneQ  <= 1'b1;
            stateQ <= ST_IDLE;
          end else if (lastElem) begin
            vlOutQ <= vlQ;
            doneQ  <= 1'b1;
            stateQ <= ST_IDLE;
          end else begin
            idxQ <= idxQ + IDX_W'(1);
          end
        end
      endcase
    end
  end

  assign idx   = idxQ;
  assign busy  = (stateQ == ST_RUN);
  assign done  = doneQ;
  assign vlOut = vlOutQ;

  assert_idx_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (VL_W'(idxQ) < vlQ));

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_zero_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vlIn == '0) |=> (done && vlOut == '0 && !busy));

  assert_cut_at_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && elemFail) |=> (done && !busy && vlOut == VL_W'($past(idxQ))));

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !elemFail && !lastElem) |=> (busy && vlQ == $past(vlQ)));

endmodule

// File: rtl/vseq_dpath.sv
module vseq_dpath
  import vseq_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int XLEN    = 64,
  parameter int CR_BASE = 8,
  parameter int IDX_W   = $clog2(MAX_VL),
  parameter int CA_W    = $clog2(CR_BASE + MAX_VL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrb_t          strb,
  input  logic [IDX_W-1:0]   idx,
  input  seqCfg_t            cfgIn,
  input  logic [XLEN-1:0]    r3In,
  input  logic [XLEN-1:0]    r10In,
  input  logic [XLEN-1:0]    r30In,
  input  logic [4*MAX_VL-1:0] bankIn,
  input  logic [XLEN-1:0]    aluResult,
  input  logic [3:0]         aluCond,
  output logic               aluReq,
  output logic               resWe,
  output logic               resZero,
  output logic [XLEN-1:0]    resData,
  output logic               condWe,
  output logic [CA_W-1:0]    condAddr,
  output logic               elemFail
);

  seqCfg_t             cfgQ;
  logic [XLEN-1:0]     r3Q, r10Q, r30Q;
  logic [4*MAX_VL-1:0] bankQ;
  logic [MAX_VL-1:0]   predVec;
  logic                pred, testOk, isFfirst, isPred;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgQ  <= '0;
      r3Q   <= '0;
      r10Q  <= '0;
      r30Q  <= '0;
      bankQ <= '0;
    end else if (strb.load) begin
      cfgQ  <= cfgIn;
      r3Q   <= r3In;
      r10Q  <= r10In;
      r30Q  <= r30In;
      bankQ <= bankIn;
    end
  end

  for (genvar g = 0; g < MAX_VL; g++) begin : g_pred
    assign predVec[g] = predOf(cfgQ.maskKind, cfgQ.maskCode, r3Q[g], r10Q[g], r30Q[g],
                               (r3Q == XLEN'(g)), bankQ[4*g +: 4]);
  end

  assign pred     = predVec[idx];
  assign testOk   = condBitTest(aluCond, cfgQ.testSel, cfgQ.testInv);
  assign isFfirst = (cfgQ.modeSel == MODE_FFIRST);
  assign isPred   = (cfgQ.modeSel == MODE_PRED);
  assign aluReq   = strb.active && pred;
  assign elemFail = aluReq && isFfirst && !testOk;
  assign condAddr = CA_W'(CR_BASE) + CA_W'(idx);

  always_comb begin
    resWe   = 1'b0;
    resZero = 1'b0;
    condWe  = 1'b0;
    if (strb.active) begin
      if (pred) begin
        if (isFfirst && !testOk) begin
          resWe = 1'b0;
        end else if (isPred && !testOk) begin
          condWe  = cfgQ.rcEn;
          resWe   = cfgQ.zeroEn;
          resZero = cfgQ.zeroEn;
        end else begin
          resWe  = 1'b1;
          condWe = cfgQ.rcEn;
        end
      end else if (cfgQ.zeroEn) begin
        resWe   = 1'b1;
        resZero = 1'b1;
      end
    end
  end

  assign resData = resZero ? '0 : aluResult;

  assert_data_from_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resWe && !resZero) |-> aluReq);

  assert_zero_no_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resZero && !aluReq) |-> !condWe);

  assert_cond_needs_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    condWe |-> aluReq);

  assert_fail_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    elemFail |-> (!resWe && !condWe));

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int XLEN    = 64,
  parameter int CR_BASE = 8,
  parameter int VL_W    = $clog2(MAX_VL + 1),
  parameter int IDX_W   = $clog2(MAX_VL),
  parameter int CA_W    = $clog2(CR_BASE + MAX_VL)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [VL_W-1:0]     vlIn,
  input  logic                maskKind,
  input  logic [2:0]          maskCode,
  input  logic [1:0]          modeSel,
  input  logic                testInv,
  input  logic [1:0]          testSel,
  input  logic                zeroEn,
  input  logic                rcEn,
  input  logic [XLEN-1:0]     r3Val,
  input  logic [XLEN-1:0]     r10Val,
  input  logic [XLEN-1:0]     r30Val,
  input  logic [4*MAX_VL-1:0] condBank,
  input  logic [XLEN-1:0]     aluResult,
  input  logic [3:0]          aluCond,
  output logic                aluReq,
  output logic [IDX_W-1:0]    aluIdx,
  output logic                resWe,
  output logic                resZero,
  output logic [IDX_W-1:0]    resIdx,
  output logic [XLEN-1:0]     resData,
  output logic                condWe,
  output logic [CA_W-1:0]     condAddr,
  output logic [3:0]          condData,
  output logic                busy,
  output logic                done,
  output logic [VL_W-1:0]     vlOut
);

  ctrlStrb_t        strb;
  logic [IDX_W-1:0] idx;
  logic             elemFail;
  seqCfg_t          cfgIn;

  assign cfgIn = '{maskKind: maskKind, maskCode: maskCode, modeSel: modeSel,
                   testInv: testInv, testSel: testSel, zeroEn: zeroEn, rcEn: rcEn};

  vseq_ctrl #(.MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vlIn(vlIn), .elemFail(elemFail),
    .strb(strb), .idx(idx), .busy(busy), .done(done), .vlOut(vlOut)
  );

  vseq_dpath #(.MAX_VL(MAX_VL), .XLEN(XLEN), .CR_BASE(CR_BASE),
               .IDX_W(IDX_W), .CA_W(CA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .idx(idx), .cfgIn(cfgIn),
    .r3In(r3Val), .r10In(r10Val), .r30In(r30Val), .bankIn(condBank),
    .aluResult(aluResult), .aluCond(aluCond), .aluReq(aluReq),
    .resWe(resWe), .resZero(resZero), .resData(resData),
    .condWe(condWe), .condAddr(condAddr), .elemFail(elemFail)
  );

  assign aluIdx   = idx;
  assign resIdx   = idx;
  assign condData = aluCond;

endmodule

// File: tb/vec_elem_seq_bench.sv
module vec_elem_seq_bench;

  localparam int MAX_VL = 64;
  localparam int XLEN   = 64;
  localparam int VL_W   = 7;
  localparam int IDX_W  = 6;
  localparam int CA_W   = 7;

  typedef struct {
    bit       isCond;
    bit       zero;
    int       addr;
    logic [XLEN-1:0] data;
    string    req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VL_W-1:0] vlIn = '0;
  logic maskKind = 1'b0;
  logic [2:0] maskCode = '0;
  logic [1:0] modeSel = '0;
  logic testInv = 1'b0;
  logic [1:0] testSel = '0;
  logic zeroEn = 1'b0;
  logic rcEn = 1'b0;
  logic [XLEN-1:0] r3Val = '0, r10Val = '0, r30Val = '0;
  logic [4*MAX_VL-1:0] condBank = '0;
  logic [XLEN-1:0] aluResult;
  logic [3:0] aluCond;
  logic aluReq, resWe, resZero, condWe, busy, done;
  logic [IDX_W-1:0] aluIdx, resIdx;
  logic [XLEN-1:0] resData;
  logic [CA_W-1:0] condAddr;
  logic [3:0] condData;
  logic [VL_W-1:0] vlOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  item_t expQ[$];

  always #5 clk = ~clk;

  vec_elem_seq u_vec_elem_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vlIn(vlIn), .maskKind(maskKind),
    .maskCode(maskCode), .modeSel(modeSel), .testInv(testInv), .testSel(testSel),
    .zeroEn(zeroEn), .rcEn(rcEn), .r3Val(r3Val), .r10Val(r10Val), .r30Val(r30Val),
    .condBank(condBank), .aluResult(aluResult), .aluCond(aluCond), .aluReq(aluReq),
    .aluIdx(aluIdx), .resWe(resWe), .resZero(resZero), .resIdx(resIdx),
    .resData(resData), .condWe(condWe), .condAddr(condAddr), .condData(condData),
    .busy(busy), .done(done), .vlOut(vlOut)
  );

  function automatic logic [XLEN-1:0] resModel(int i);
    return 64'h5A00_0000_0000_0000 | XLEN'(i * 7 + 3);
  endfunction

  function automatic logic [3:0] condModel(int i);
    return 4'((i * 5) + 3);
  endfunction

  always_comb begin
    aluResult = resModel(int'(aluIdx));
    aluCond   = condModel(int'(aluIdx));
  end

  function automatic bit bitTest(logic [3:0] c, int sel, bit inv);
    return c[3 - sel] ^ inv;
  endfunction

  // R2/R3 predicate model
  function automatic bit predModel(bit kind, int code, logic [XLEN-1:0] a,
                                   logic [XLEN-1:0] b, logic [XLEN-1:0] c,
                                   logic [4*MAX_VL-1:0] bank, int i);
    if (kind) return bitTest(bank[4*i +: 4], code / 2, bit'(code % 2));
    case (code)
      0: return 1'b1;
      1: return a == XLEN'(i);
      2: return a[i];
      3: return !a[i];
      4: return b[i];
      5: return !b[i];
      6: return c[i];
      default: return !c[i];
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pushRes(int i, bit z, string req);
    item_t it;
    it.isCond = 0; it.zero = z; it.addr = i;
    it.data = z ? '0 : resModel(i); it.req = req;
    expQ.push_back(it);
  endtask

  task automatic pushCond(int i, string req);
    item_t it;
    it.isCond = 1; it.zero = 0; it.addr = 8 + i;
    it.data = XLEN'(condModel(i)); it.req = req;
    expQ.push_back(it);
  endtask

  // monitor: pops and compares each produced write
  always @(negedge clk) begin
    if (rst_n) begin
      item_t it;
      if (resWe) begin
        if (expQ.size() == 0) begin
          check(0, "R5", "unexpected result write idx", XLEN'(resIdx), '0);
        end else begin
          it = expQ.pop_front();
          check(!it.isCond && it.addr == int'(resIdx) && resData == it.data && resZero == it.zero,
                it.req, "result write idx/data", {XLEN'(resIdx) << 56} | resData,
                {XLEN'(it.addr) << 56} | it.data);
        end
      end
      if (condWe) begin
        if (expQ.size() == 0) begin
          check(0, "R5", "unexpected cond write addr", XLEN'(condAddr), '0);
        end else begin
          it = expQ.pop_front();
          check(it.isCond && it.addr == int'(condAddr) && XLEN'(condData) == it.data,
                it.req, "cond write addr/data", {XLEN'(condAddr) << 8} | XLEN'(condData),
                {XLEN'(it.addr) << 8} | it.data);
        end
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      finishRun();
    end
  end

  task automatic runCase(string req, int vl, bit kind, int code, int mode, bit inv, int sel,
                         bit zero, bit rc, logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                         logic [XLEN-1:0] c, logic [4*MAX_VL-1:0] bank, bit glitch);
    int vlExp = vl;
    int waitCnt = 0;
    for (int i = 0; i < vl; i++) begin
      bit p = predModel(kind, code, a, b, c, bank, i);
      bit t = bitTest(condModel(i), sel, inv);
      if (p) begin
        if (mode == 1 && !t) begin
          vlExp = i;
          break;
        end else if (mode == 3 && !t) begin
          if (zero) pushRes(i, 1, "R10");
          if (rc) pushCond(i, "R10");
        end else begin
          pushRes(i, 0, req);
          if (rc) pushCond(i, "R7");
        end
      end else if (zero) begin
        pushRes(i, 1, "R6");
      end
    end
    @(negedge clk);
    vlIn = VL_W'(vl); maskKind = kind; maskCode = 3'(code); modeSel = 2'(mode);
    testInv = inv; testSel = 2'(sel); zeroEn = zero; rcEn = rc;
    r3Val = a; r10Val = b; r30Val = c; condBank = bank; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      // R11: a second start while busy with other settings must be ignored
      start = 1'b1; vlIn = 7'd1; maskCode = 3'd7; zeroEn = 1'b0; r30Val = '0;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && waitCnt < 500) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done == 1'b1, req, "done pulse", XLEN'(done), 1);
    check(vlOut == VL_W'(vlExp), req, "final VL", XLEN'(vlOut), XLEN'(vlExp));
    check(expQ.size() == 0, req, "missing writes", XLEN'(expQ.size()), 0);
    expQ.delete();
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R1", "done single cycle", XLEN'(done), 0);
  endtask

  initial begin
    logic [4*MAX_VL-1:0] bank;
    for (int i = 0; i < MAX_VL; i++) bank[4*i +: 4] = 4'((i * 3) + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!resWe && !condWe && !aluReq && !busy && !done && vlOut == '0,
          "R1", "reset outputs", {63'b0, resWe | condWe | aluReq | busy | done}, 0);

    // R1/R7: every element, condition fields stored
    runCase("R1", 5, 0, 0, 0, 0, 0, 0, 1, '0, '0, '0, bank, 0);
    // R2: index equality against r3Val, R5 skipped elements silent
    runCase("R2", 4, 0, 1, 0, 0, 0, 0, 0, 64'd2, '0, '0, bank, 0);
    // R2/R6: r3 bit-set with zeroing
    runCase("R6", 8, 0, 2, 0, 0, 0, 1, 1, 64'hA5, '0, '0, bank, 0);
    // R2: inverted r10, r30 bits; R5 without zeroing
    runCase("R5", 10, 0, 5, 0, 0, 0, 0, 1, '0, 64'h0F3, '0, bank, 0);
    runCase("R2", 12, 0, 6, 2, 0, 0, 0, 0, '0, '0, 64'hC3C, bank, 0);
    // R3: each selector, plain and inverted
    for (int code = 0; code < 8; code++)
      runCase("R3", 9, 1, code, 0, 0, 0, 1, 0, '0, '0, '0, bank, 0);
    // R4: zero length
    runCase("R4", 0, 0, 0, 0, 0, 0, 1, 1, '0, '0, '0, bank, 0);
    // R9: element 0 fails (cond 0011, LT clear)
    runCase("R9", 6, 0, 0, 1, 0, 0, 0, 1, '0, '0, '0, bank, 0);
    // R8: mid-run failure (LT inverted: passes at 0, fails at 1)
    runCase("R8", 6, 0, 0, 1, 1, 0, 0, 1, '0, '0, '0, bank, 0);
    // R8: masked elements skip the test, later failure
    runCase("R8", 12, 0, 4, 1, 0, 1, 1, 1, '0, 64'hFFC, '0, bank, 0);
    // R8: SO-bit test, also run with no failure path possible via mask
    runCase("R8", 7, 0, 1, 1, 0, 3, 0, 1, 64'd4, '0, '0, bank, 0);
    // R10: predicate-result without and with zeroing
    runCase("R10", 10, 0, 0, 3, 0, 2, 0, 1, '0, '0, '0, bank, 0);
    runCase("R10", 10, 0, 6, 3, 1, 1, 1, 1, '0, '0, 64'h2B7, bank, 0);
    // R11: restart attempt during a run
    runCase("R11", 6, 0, 6, 0, 0, 0, 1, 1, '0, '0, 64'h15, bank, 1);
    // R1: full length
    runCase("R1", MAX_VL, 0, 0, 0, 0, 0, 0, 1, '0, '0, '0, bank, 0);
    finishRun();
  end

endmodule